// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block is the transmit side of a multi-slot TDM / I2S audio port. Parallel 32-bit sample words arrive from a FIFO-style source (`sample_vld_i` / `sample_pop_o`). The block shifts them out one bit per bit-clock period on `sdata_o`. Frames are aligned to an externally generated bit clock and frame sync. Clock generation, DMA and the receive path live elsewhere.

The bit clock and the frame-sync lines are sampled on `clk_i` and must be synchronous to it. The block acts on a bit-clock transition in the same `clk_i` cycle in which it first sees the transition. A packed configuration word sets the following: the number of slots, the slot width as a coded value, the drive edge, the bit order and the frame-sync source. Two further inputs set the per-slot mute mask and the delay between sync and the first data bit. The `en_i` and `srst_i` inputs start and stop the serializer.

Top module: `tdm_serializer`

## Requirements
- R1: `cfg_i[3:0]` holds slots-per-frame minus one (1 to 16 slots). A frame carries exactly slots × width data bits. After the last one, `sdata_o` stays 0 until the next frame starts.
- R2: `cfg_i[8:4]` codes the slot width: 4 gives 16 bits, 8 gives 20, 12 gives 24, 16 gives 32. For any other code, or when any of bits 9 or 15:12 is nonzero, the block stays idle: `sdata_o` is 0 and nothing is popped.
- R3: `cfg_i[10]` picks the drive edge. At 0, `sdata_o` changes only at falling `bclk_i` edges; at 1, it changes only at rising edges.
- R4: Only the top width bits of each 32-bit word are sent. With `cfg_i[11]` = 0 the first bit is word bit 31 and the bits go downward. With `cfg_i[11]` = 1 the first bit is word bit 32−width and the bits go upward.
- R5: `cfg_i[18:16]` = k (1 to N_SYNC) makes the block follow `fsync_i[k-1]`. A value of 0, a value above N_SYNC, or a pulse on any other line, starts no frame.
- R6: A frame starts at a drive edge where the selected sync is high after being low at the previous drive edge. The first data bit appears `bit_start_i` drive edges later; with 0 it appears at that same edge.
- R7: A set bit n of `slot_off_i` mutes slot n. The slot drives zeros and pops no sample.
- R8: At the first bit of each unmuted slot, the block pops one sample if `sample_vld_i` is high. If it is low, that slot drives zeros (underrun) and nothing is popped.
- R9: While `en_i` is low or `srst_i` is high, `sdata_o` is 0 and nothing is popped. Frame progress is discarded, so no output resumes without a new sync rise.
- R10: `sdata_o` changes only in a `clk_i` cycle in which a drive edge of `bclk_i` is seen.
- R11: During and right after reset, `sdata_o` and `sample_pop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Serializer enable |
| srst_i | input | 1 | Serializer soft reset, high clears frame state |
| cfg_i | input | 19 | Slot count, width code, drive edge, bit order, sync source |
| bit_start_i | input | BS_W | Drive edges from sync rise to the first data bit |
| slot_off_i | input | 16 | Per-slot mute mask, 1 = slot silent |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| fsync_i | input | N_SYNC | Candidate frame-sync lines |
| sample_i | input | 32 | Head-of-FIFO sample word, left aligned |
| sample_vld_i | input | 1 | Sample word available |
| sample_pop_o | output | 1 | One-cycle pop of the head sample |
| sdata_o | output | 1 | Serial data out |

## Verification
A slot or bit counter that is off by one shifts every later bit of the frame by one drive edge. This shows at `sdata_o` from the first affected bit onward, at the latest within one slot. A wrong delay count moves the first data bit, which shows at the first drive edge of the frame. A missed or extra pop misaligns whole samples, which shows as wrong data in the next unmuted slot and as a wrong pop count when the frame ends. Sampling on the wrong bit-clock edge shows within one bit period as a change of `sdata_o` on the non-driving half.

// File: rtl/tdmser_pkg.sv
package tdmser_pkg;
  localparam int WORD_W   = 32;
  localparam int SLOT_MAX = 16;
  localparam int CFG_W    = 19;

  typedef struct packed {
    logic [2:0] sync_sel;
    logic [3:0] rsv_hi;
    logic       lsb_first;
    logic       drive_rise;
    logic       rsv_9;
    logic [4:0] wcode;
    logic [3:0] nslots_m1;
  } tdmser_cfg_t;

  function automatic logic [5:0] slot_bits(input logic [4:0] code);
    case (code)
      5'd4:    slot_bits = 6'd16;
      5'd8:    slot_bits = 6'd20;
      5'd12:   slot_bits = 6'd24;
      5'd16:   slot_bits = 6'd32;
      default: slot_bits = 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/tdmser_seq.sv
module tdmser_seq #(
  parameter int BS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            pol_i,
  input  logic            bclk_i,
  input  logic            sync_i,
  input  logic [BS_W-1:0] bit_start_i,
  input  logic [3:0]      nslots_m1_i,
  input  logic [5:0]      width_i,
  output logic            tick_o,
  output logic            drive_o,
  output logic            slot_start_o,
  output logic [3:0]      slot_o,
  output logic [4:0]      bit_o
);
  logic            bclk_q, sync_q, pend_q, busy_q;
  logic [BS_W-1:0] wcnt_q, wcnt_e;
  logic [3:0]      slot_q, slot_n;
  logic [4:0]      bit_q, bit_n;
  logic            rise, pend_e, start, last_bit, drive;

  assign tick_o = run_i & (pol_i ? (bclk_i & ~bclk_q) : (~bclk_i & bclk_q));

  always_comb begin
    rise     = sync_i & ~sync_q;
    pend_e   = rise | pend_q;
    wcnt_e   = rise ? bit_start_i : wcnt_q;
    start    = pend_e & (wcnt_e == '0);
    last_bit = ({1'b0, bit_q} == width_i - 6'd1);
    drive    = 1'b0;
    slot_n   = slot_q;
    bit_n    = bit_q;
    if (start) begin
      drive  = 1'b1;
      slot_n = '0;
      bit_n  = '0;
    end else if (busy_q) begin
      if (!last_bit) begin
        drive = 1'b1;
        bit_n = bit_q + 5'd1;
      end else if (slot_q != nslots_m1_i) begin
        drive  = 1'b1;
        slot_n = slot_q + 4'd1;
        bit_n  = '0;
      end
    end
  end

  assign drive_o      = drive;
  assign slot_o       = slot_n;
  assign bit_o        = bit_n;
  assign slot_start_o = tick_o & drive & (bit_n == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      wcnt_q <= '0;
      slot_q <= '0;
      bit_q  <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (!run_i) begin
        sync_q <= 1'b0;
        pend_q <= 1'b0;
        busy_q <= 1'b0;
        wcnt_q <= '0;
        slot_q <= '0;
        bit_q  <= '0;
      end else if (tick_o) begin
        sync_q <= sync_i;
        pend_q <= pend_e & ~start;
        wcnt_q <= start ? '0 : (pend_e ? wcnt_e - 1'b1 : wcnt_q);
        busy_q <= drive;
        slot_q <= slot_n;
        bit_q  <= bit_n;
      end
    end
  end

  p_bit_below_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    busy_q |-> ({1'b0, bit_q} < width_i));
  p_slot_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    busy_q |-> (slot_q <= nslots_m1_i));
  p_delay_pending_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    (tick_o && sync_i && !sync_q && bit_start_i != '0) |=> pend_q);
endmodule

// File: rtl/tdmser_shift.sv
module tdmser_shift
  import tdmser_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                tick_i,
  input  logic                drive_i,
  input  logic                slot_start_i,
  input  logic [3:0]          slot_i,
  input  logic [4:0]          bit_i,
  input  logic [5:0]          width_i,
  input  logic                lsb_first_i,
  input  logic [SLOT_MAX-1:0] slot_off_i,
  input  logic [WORD_W-1:0]   sample_i,
  input  logic                sample_vld_i,
  output logic                pop_o,
  output logic                sdata_o
);
  logic [WORD_W-1:0] word_q, word_e;
  logic              slot_on, take;
  logic [4:0]        pos;

  assign slot_on = ~slot_off_i[slot_i];
  assign take    = slot_start_i & slot_on & sample_vld_i;
  assign pop_o   = take;
  assign word_e  = slot_start_i ? (take ? sample_i : '0) : word_q;
  // left-aligned sample: LSB-first starts at bit 32-width
  assign pos = lsb_first_i ? 5'(6'd32 - width_i + 6'(bit_i)) : (5'd31 - bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      sdata_o <= 1'b0;
    end else if (!run_i) begin
      word_q  <= '0;
      sdata_o <= 1'b0;
    end else if (tick_i) begin
      word_q  <= word_e;
      sdata_o <= drive_i & word_e[pos];
    end
  end

  p_mute_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && drive_i && slot_off_i[slot_i]) |=> !sdata_o);
  p_underrun_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_i && !sample_vld_i) |=> !sdata_o);
  p_hold_between_edges_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(sdata_o));
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
  import tdmser_pkg::*;
#(
  parameter int N_SYNC = 7,
  parameter int BS_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                srst_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [BS_W-1:0]     bit_start_i,
  input  logic [SLOT_MAX-1:0] slot_off_i,
  input  logic                bclk_i,
  input  logic [N_SYNC-1:0]   fsync_i,
  input  logic [WORD_W-1:0]   sample_i,
  input  logic                sample_vld_i,
  output logic                sample_pop_o,
  output logic                sdata_o
);
  tdmser_cfg_t cfg;
  logic [5:0]  width;
  logic        run, sync_lvl, sel_ok;
  logic        tick, drive, slot_start;
  logic [3:0]  slot;
  logic [4:0]  bit_idx;

  assign cfg    = tdmser_cfg_t'(cfg_i);
  assign width  = slot_bits(cfg.wcode);
  assign sel_ok = (cfg.sync_sel != 3'd0) && (int'(cfg.sync_sel) <= N_SYNC);
  assign run    = en_i & ~srst_i & sel_ok & (width != 6'd0) &
                  (cfg.rsv_hi == 4'd0) & ~cfg.rsv_9;

  always_comb begin
    sync_lvl = 1'b0;
    for (int i = 0; i < N_SYNC; i++)
      if (int'(cfg.sync_sel) == i + 1) sync_lvl = fsync_i[i];
  end

  tdmser_seq #(.BS_W(BS_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .pol_i        (cfg.drive_rise),
    .bclk_i       (bclk_i),
    .sync_i       (sync_lvl),
    .bit_start_i  (bit_start_i),
    .nslots_m1_i  (cfg.nslots_m1),
    .width_i      (width),
    .tick_o       (tick),
    .drive_o      (drive),
    .slot_start_o (slot_start),
    .slot_o       (slot),
    .bit_o        (bit_idx)
  );

  tdmser_shift u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .tick_i       (tick),
    .drive_i      (drive),
    .slot_start_i (slot_start),
    .slot_i       (slot),
    .bit_i        (bit_idx),
    .width_i      (width),
    .lsb_first_i  (cfg.lsb_first),
    .slot_off_i   (slot_off_i),
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .pop_o        (sample_pop_o),
    .sdata_o      (sdata_o)
  );

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !sdata_o);
endmodule

// File: tb/tdm_serializer_bench.sv
`timescale 1ns/1ps
module tdm_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, srst = 1'b0;
  logic [18:0] cfg = '0;
  logic [7:0]  bstart = '0;
  logic [15:0] soff = '0;
  logic        bclk = 1'b0;
  logic [6:0]  fs = '0;
  logic [31:0] smp;
  logic        smp_vld, pop, sdata;
  logic [31:0] fifo_mem [0:31];
  int          fifo_cnt = 0;
  logic [5:0]  rd_ptr;
  logic        fifo_clr = 1'b1;
  int          nchk = 0, nerr = 0;
  logic        dl_g = 1'b0, prev_g = 1'b0, got_g;
  int          stab_g = 0;

  always #5 clk = ~clk;

  tdm_serializer u_tdm_serializer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .srst_i(srst), .cfg_i(cfg),
    .bit_start_i(bstart), .slot_off_i(soff), .bclk_i(bclk), .fsync_i(fs),
    .sample_i(smp), .sample_vld_i(smp_vld), .sample_pop_o(pop), .sdata_o(sdata)
  );

  assign smp_vld = (int'(rd_ptr) < fifo_cnt);
  assign smp     = fifo_mem[rd_ptr[4:0]];
  always @(posedge clk)
    if (fifo_clr) rd_ptr <= '0;
    else if (pop) rd_ptr <= rd_ptr + 6'd1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input int code);
    case (code)
      4: return 16; 8: return 20; 12: return 24; 16: return 32;
      default: return 0;
    endcase
  endfunction

  // one bit-clock period: non-drive half, then drive half; sample after the drive edge
  task automatic tick(input bit pulse, input int line);
    bclk = ~dl_g;
    @(negedge clk);
    if (sdata !== prev_g) stab_g++;
    bclk = dl_g;
    fs = '0;
    if (pulse) fs[line] = 1'b1;
    @(negedge clk);
    got_g  = sdata;
    prev_g = sdata;
  endtask

  function automatic logic exp_bit(input int e, input int nsl, input int w, input int b,
                                   input logic [15:0] off, input int nwords, input bit lsb);
    int pos, slot, k, idx;
    logic [31:0] word;
    pos = e - b;
    if (w == 0 || pos < 0 || pos >= nsl * w) return 1'b0;
    slot = pos / w;
    k = pos % w;
    if (off[slot]) return 1'b0;
    idx = 0;
    for (int s = 0; s < slot; s++) if (!off[s]) idx++;
    if (idx >= nwords) return 1'b0;
    word = fifo_mem[idx];
    return lsb ? word[32 - w + k] : word[31 - k];
  endfunction

  task automatic setup(input int nsl, input int wcode, input bit pol, input bit lsb, input int sel,
                       input int b, input logic [15:0] off, input int nwords, input int seed);
    @(negedge clk);
    en = 1'b0;
    srst = 1'b0;
    fifo_clr = 1'b1;
    for (int j = 0; j < 32; j++) fifo_mem[j] = (32'h9E37_79B9 * (j + 1 + seed)) ^ 32'h5A5A_0F0F;
    fifo_cnt = nwords;
    cfg = '0;
    cfg[3:0] = 4'(nsl - 1);
    cfg[8:4] = 5'(wcode);
    cfg[10] = pol;
    cfg[11] = lsb;
    cfg[18:16] = 3'(sel);
    bstart = 8'(b);
    soff = off;
    dl_g = pol;
    bclk = ~pol;
    fs = '0;
    @(negedge clk);
    fifo_clr = 1'b0;
    en = 1'b1;
    @(negedge clk);
    prev_g = sdata;
    stab_g = 0;
  endtask

  task automatic run_frame(input int nsl, input int wcode, input bit pol, input bit lsb, input int sel,
                           input int line, input int b, input logic [15:0] off, input int nwords,
                           input int seed, input bit on, input string tag);
    int w, total, mism, first_e, exp_pops, en_slots;
    logic e_bit;
    w = width_of(wcode);
    setup(nsl, wcode, pol, lsb, sel, b, off, nwords, seed);
    total = b + nsl * (w == 0 ? 16 : w) + 4;
    mism = 0;
    first_e = -1;
    for (int e = 0; e < total; e++) begin
      tick(e == 0, line);
      e_bit = on ? exp_bit(e, nsl, w, b, off, nwords, lsb) : 1'b0;
      if (got_g !== e_bit) begin
        mism++;
        if (first_e < 0) first_e = e;
      end
    end
    check(mism == 0, tag, "serial bit mismatches", mism, 0);
    if (mism != 0) $display("  first mismatching drive edge %0d", first_e);
    check(stab_g == 0, "R10", "changes on non-drive half", stab_g, 0);
    en_slots = 0;
    for (int s = 0; s < nsl; s++) if (!off[s]) en_slots++;
    exp_pops = on ? (en_slots < nwords ? en_slots : nwords) : 0;
    check(int'(rd_ptr) == exp_pops, tag, "pop count", int'(rd_ptr), exp_pops);
  endtask

  task automatic t_reset;
    #1;
    check(sdata === 1'b0, "R11", "sdata in reset", int'(sdata), 0);
    check(pop === 1'b0, "R11", "pop in reset", int'(pop), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdata === 1'b0, "R11", "sdata after reset", int'(sdata), 0);
    check(pop === 1'b0, "R11", "pop after reset", int'(pop), 0);
  endtask

  task automatic t_msb16;
    run_frame(2, 4, 1'b0, 1'b0, 1, 0, 1, 16'h0000, 4, 1, 1'b1, "R1 R4 R6 R8 msb16");
  endtask

  task automatic t_lsb24;
    run_frame(3, 12, 1'b0, 1'b1, 2, 1, 2, 16'h0000, 4, 2, 1'b1, "R2 R4 lsb24");
  endtask

  task automatic t_rise32;
    run_frame(1, 16, 1'b1, 1'b0, 3, 2, 0, 16'h0000, 2, 3, 1'b1, "R3 R6 rise32");
  endtask

  task automatic t_mute20;
    run_frame(4, 8, 1'b0, 1'b0, 1, 0, 1, 16'b0101, 4, 4, 1'b1, "R7 R2 mute20");
  endtask

  task automatic t_underrun;
    run_frame(4, 4, 1'b1, 1'b1, 1, 0, 3, 16'h0000, 2, 5, 1'b1, "R8 underrun");
  endtask

  task automatic t_max_slots;
    run_frame(16, 4, 1'b0, 1'b0, 7, 6, 0, 16'h8001, 20, 6, 1'b1, "R1 R7 sixteen slots");
  endtask

  task automatic t_bad_width;
    run_frame(2, 5, 1'b0, 1'b0, 1, 0, 0, 16'h0000, 4, 7, 1'b0, "R2 bad width code");
  endtask

  task automatic t_sync_sel;
    run_frame(2, 4, 1'b0, 1'b0, 1, 3, 0, 16'h0000, 4, 8, 1'b0, "R5 unselected line");
    run_frame(2, 4, 1'b0, 1'b0, 0, 0, 0, 16'h0000, 4, 9, 1'b0, "R5 source zero");
  endtask

  task automatic t_abort;
    int zeros, pops_before;
    setup(2, 16, 1'b0, 1'b0, 1, 0, 16'h0000, 4, 10);
    for (int e = 0; e < 6; e++) tick(e == 0, 0);
    pops_before = int'(rd_ptr);
    check(pops_before == 1, "R9", "pops before soft reset", pops_before, 1);
    srst = 1'b1;
    zeros = 0;
    for (int e = 0; e < 8; e++) begin
      tick(1'b0, 0);
      if (got_g === 1'b0) zeros++;
    end
    check(zeros == 8, "R9", "zero edges under soft reset", zeros, 8);
    srst = 1'b0;
    prev_g = sdata;
    zeros = 0;
    for (int e = 0; e < 40; e++) begin
      tick(1'b0, 0);
      if (got_g === 1'b0) zeros++;
    end
    check(zeros == 40, "R9", "no resume without sync", zeros, 40);
    check(int'(rd_ptr) == pops_before, "R9", "pops after soft reset", int'(rd_ptr), pops_before);
    for (int e = 0; e < 4; e++) tick(e == 0, 0);
    en = 1'b0;
    zeros = 0;
    for (int e = 0; e < 8; e++) begin
      tick(1'b0, 0);
      if (got_g === 1'b0) zeros++;
    end
    check(zeros == 8, "R9", "zero edges with enable low", zeros, 8);
    check(int'(rd_ptr) == pops_before + 1, "R9", "pops with enable low", int'(rd_ptr), pops_before + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_msb16();
    t_lsb24();
    t_rise32();
    t_mute20();
    t_underrun();
    t_max_slots();
    t_bad_width();
    t_sync_sel();
    t_abort();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule